// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor with Speculative History

This block predicts branch direction and target for a fetch stage. It holds a small, fully associative table of branch entries matched on the full branch address. Each entry carries a stored target, a committed history of real outcomes, a speculative history that runs ahead of execution, and its own private table of 2-bit saturating counters indexed by history. A fetch-time lookup reads the counter selected by the entry's history and reports hit, predicted direction and target. It then pushes that predicted direction into the entry's speculative history, so a later instance of the same branch fetched before the first one resolves is predicted with the guessed path included.

Counters are trained only when a branch resolves at execution. The resolve port also shifts the real outcome into the committed history and, when the branch was mispredicted, drops every speculative history back to its committed value. A separate flush input does the same drop without training anything. A resolving branch that is not in the table takes an entry chosen in round-robin order. When a lookup and a resolve arrive in the same cycle, the lookup observes the table as already updated by the resolve.

Top module: `bp_spec_hist_pred`

## Requirements
- R1: After reset every entry is empty, so every lookup misses.
- R2: A lookup that misses reports pred_hit=0, pred_taken=0 and pred_target=0. A resolve whose address is not in the table allocates an entry holding that address as tag, with the resolve target stored. A later lookup of that address hits and reports the target stored by its most recent resolve. No two entries ever hold the same tag.
- R3: Each counter is 2 bits: 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken. Counters saturate at 0 and 3. A new entry starts with every counter at 1 and its committed history at zero. The prediction is taken exactly when the selected counter is 2 or 3.
- R4: Counters change only on a resolve of their own entry. Lookups, flushes and mispredicts of other branches leave them unchanged.
- R5: A lookup indexes the counters with the entry's speculative history when one is present. Otherwise, it uses the committed history.
- R6: A lookup that hits shifts its predicted direction into that entry's speculative history at bit 0, older bits moving toward the MSB, and marks the speculative history present.
- R7: A resolve trains the counter indexed by the committed history as it stood before the resolve, toward the real outcome. It then shifts the real outcome into bit 0 of the committed history.
- R8: A resolve with the mispredict flag set, or a cycle with flush high, discards every speculative history. Lookups then use the committed history until the next prediction of that branch.
- R9: Allocation uses a round-robin pointer that starts at entry 0 and advances by one, wrapping, on every allocation. An allocation evicts whatever that entry held.
- R10: When a resolve and a lookup occur in the same cycle, the lookup sees the resolve's effects. This covers a newly allocated entry, the trained counter, the shifted committed history and any discarded speculative history.
- R11: With lk_valid low, the prediction outputs are zero and no speculative history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Fetch-time lookup request |
| lk_pc | input | PC_W | Address of the branch being looked up |
| rs_valid | input | 1 | Execution-time resolve request |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome of the resolving branch |
| rs_mispredict | input | 1 | The resolving branch was mispredicted |
| rs_target | input | PC_W | Target to store for the resolving branch |
| flush | input | 1 | Discard all speculative histories |
| pred_hit | output | 1 | Lookup matched an entry |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | PC_W | Stored target of the matched entry |

## Verification
The bench builds the block with four entries, 4-bit history and 16-bit addresses. With four entries, the fifth distinct branch wraps the replacement pointer and evicts the oldest branch within a few cycles. The 4-bit history lets a run of predicted not-taken outcomes walk the speculative history onto a counter that differs from the one the committed history selects, so the use and the discarding of speculative state become visible at the outputs. Same-cycle resolve and lookup are checked on a branch that is being allocated in that very cycle.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    localparam ctr_e CTR_INIT = CTR_WNT;

    function automatic ctr_e ctr_train(input ctr_e c, input logic up);
        ctr_e r;
        if (up) begin
            r = (c == CTR_ST) ? CTR_ST : ctr_e'(c + 2'd1);
        end else begin
            r = (c == CTR_SNT) ? CTR_SNT : ctr_e'(c - 2'd1);
        end
        return r;
    endfunction

    function automatic logic ctr_dir(input ctr_e c);
        return (c == CTR_WT) || (c == CTR_ST);
    endfunction

endpackage

// File: rtl/bp_match.sv
`timescale 1ns/1ps
module bp_match #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] key,
    input  logic [N-1:0] valid_vec,
    input  logic [W-1:0] tags [N],
    output logic [N-1:0] hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = en && valid_vec[g] && (tags[g] == key);
    end
endmodule

// File: rtl/bp_rr_ptr.sv
`timescale 1ns/1ps
module bp_rr_ptr #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        adv |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)); // R9

    AST_RR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr)); // R9
endmodule

// File: rtl/bp_entry.sv
`timescale 1ns/1ps
module bp_entry
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rs_hit,
    input  logic            rs_alloc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_pc,
    input  logic [PC_W-1:0] rs_target,
    input  logic            clr_spec,
    input  logic            lk_sel,
    output logic            cur_valid,
    output logic [PC_W-1:0] cur_tag,
    output logic            v_valid,
    output logic [PC_W-1:0] v_tag,
    output logic [PC_W-1:0] v_target,
    output logic            v_pred
);
    localparam int PHT_N = 1 << HIST_W;

    logic              valid;
    logic [PC_W-1:0]   tag;
    logic [PC_W-1:0]   target;
    logic [HIST_W-1:0] bhr;
    logic [HIST_W-1:0] spec;
    logic              spec_valid;
    ctr_e              pht [PHT_N];

    logic              rs_upd;
    logic [HIST_W-1:0] base_bhr;
    ctr_e              base_ctr;
    ctr_e              trained;
    logic [HIST_W-1:0] n_bhr;
    logic              n_spec_valid;
    logic [HIST_W-1:0] v_hist;
    ctr_e              v_ctr;
    logic [2*PHT_N-1:0] pht_flat;

    // State as it stands once this cycle's resolve has been applied.
    always_comb begin
        rs_upd       = rs_hit | rs_alloc;
        base_bhr     = rs_alloc ? '0 : bhr;
        base_ctr     = rs_alloc ? CTR_INIT : pht[base_bhr];
        trained      = ctr_train(base_ctr, rs_taken);
        n_bhr        = rs_upd ? {base_bhr[HIST_W-2:0], rs_taken} : bhr;
        n_spec_valid = spec_valid & ~clr_spec & ~rs_alloc;
        v_hist       = n_spec_valid ? spec : n_bhr;
        if (rs_upd && (v_hist == base_bhr)) begin
            v_ctr = trained;
        end else if (rs_alloc) begin
            v_ctr = CTR_INIT;
        end else begin
            v_ctr = pht[v_hist];
        end
        v_pred = ctr_dir(v_ctr);
    end

    assign cur_valid = valid;
    assign cur_tag   = tag;
    assign v_valid   = valid | rs_alloc;
    assign v_tag     = rs_alloc ? rs_pc : tag;
    assign v_target  = rs_upd ? rs_target : target;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid      <= 1'b0;
            tag        <= '0;
            target     <= '0;
            bhr        <= '0;
            spec       <= '0;
            spec_valid <= 1'b0;
            for (int i = 0; i < PHT_N; i++) begin
                pht[i] <= CTR_INIT;
            end
        end else begin
            if (rs_alloc) begin
                valid <= 1'b1;
                tag   <= rs_pc;
                for (int i = 0; i < PHT_N; i++) begin
                    pht[i] <= CTR_INIT;
                end
            end
            if (rs_upd) begin
                target         <= rs_target;
                bhr            <= n_bhr;
                pht[base_bhr]  <= trained;
            end
            if (lk_sel) begin
                spec       <= {v_hist[HIST_W-2:0], v_pred};
                spec_valid <= 1'b1;
            end else begin
                spec_valid <= n_spec_valid;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < PHT_N; i++) begin
            pht_flat[2*i +: 2] = pht[i];
        end
    end

    AST_PHT_ONLY_AT_RESOLVE: assert property (@(posedge clk) disable iff (rst)
        !rs_upd |=> $stable(pht_flat)); // R4

    AST_BHR_TAKES_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rs_upd |=> bhr[0] == $past(rs_taken)); // R7

    AST_SPEC_TAKES_PREDICTION: assert property (@(posedge clk) disable iff (rst)
        lk_sel |=> spec_valid && (spec[0] == $past(v_pred))); // R6

    AST_SPEC_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (clr_spec && !lk_sel) |=> !spec_valid); // R8
endmodule

// File: rtl/bp_spec_hist_pred.sv
`timescale 1ns/1ps
module bp_spec_hist_pred #(
    parameter int ENTRIES = 16,
    parameter int HIST_W  = 4,
    parameter int PC_W    = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic            rs_mispredict,
    input  logic [PC_W-1:0] rs_target,
    input  logic            flush,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] cur_valid;
    logic [PC_W-1:0]    cur_tag  [ENTRIES];
    logic [ENTRIES-1:0] v_valid;
    logic [PC_W-1:0]    v_tag    [ENTRIES];
    logic [PC_W-1:0]    v_target [ENTRIES];
    logic [ENTRIES-1:0] v_pred;

    logic [ENTRIES-1:0] rs_hit_vec;
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] alloc_vec;
    logic [IDX_W-1:0]   rr_ptr;
    logic               rs_miss;
    logic               clr_spec;

    assign rs_miss  = rs_valid && !(|rs_hit_vec);
    assign clr_spec = flush || (rs_valid && rs_mispredict);

    bp_match #(.N(ENTRIES), .W(PC_W)) u_rs_match (
        .en        (rs_valid),
        .key       (rs_pc),
        .valid_vec (cur_valid),
        .tags      (cur_tag),
        .hit_vec   (rs_hit_vec)
    );

    bp_rr_ptr #(.N(ENTRIES)) u_rr (
        .clk (clk),
        .rst (rst),
        .adv (rs_miss),
        .ptr (rr_ptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign alloc_vec[g] = rs_miss && (rr_ptr == IDX_W'(g));

        bp_entry #(.PC_W(PC_W), .HIST_W(HIST_W)) u_ent (
            .clk       (clk),
            .rst       (rst),
            .rs_hit    (rs_hit_vec[g]),
            .rs_alloc  (alloc_vec[g]),
            .rs_taken  (rs_taken),
            .rs_pc     (rs_pc),
            .rs_target (rs_target),
            .clr_spec  (clr_spec),
            .lk_sel    (lk_hit_vec[g]),
            .cur_valid (cur_valid[g]),
            .cur_tag   (cur_tag[g]),
            .v_valid   (v_valid[g]),
            .v_tag     (v_tag[g]),
            .v_target  (v_target[g]),
            .v_pred    (v_pred[g])
        );
    end

    // Lookup compares against the post-resolve view of every entry.
    bp_match #(.N(ENTRIES), .W(PC_W)) u_lk_match (
        .en        (lk_valid),
        .key       (lk_pc),
        .valid_vec (v_valid),
        .tags      (v_tag),
        .hit_vec   (lk_hit_vec)
    );

    always_comb begin
        pred_hit    = |lk_hit_vec;
        pred_taken  = 1'b0;
        pred_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i]) begin
                pred_taken  = pred_taken | v_pred[i];
                pred_target = pred_target | v_target[i];
            end
        end
    end

    AST_ONE_RESOLVE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rs_hit_vec)); // R2

    AST_ONE_LOOKUP_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec)); // R2

    AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (!pred_taken && (pred_target == '0))); // R2

    AST_IDLE_LOOKUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !pred_hit); // R11

    AST_ALLOC_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (|alloc_vec) |-> (rs_valid && $onehot(alloc_vec))); // R9
endmodule

// File: tb/bp_spec_hist_pred_tb.sv
`timescale 1ns/1ps
module bp_spec_hist_pred_tb;
    localparam int ENTRIES = 4;
    localparam int HIST_W  = 4;
    localparam int PC_W    = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            lk_valid = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            rs_valid = 1'b0;
    logic [PC_W-1:0] rs_pc = '0;
    logic            rs_taken = 1'b0;
    logic            rs_mispredict = 1'b0;
    logic [PC_W-1:0] rs_target = '0;
    logic            flush = 1'b0;
    logic            pred_hit;
    logic            pred_taken;
    logic [PC_W-1:0] pred_target;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    bp_spec_hist_pred #(.ENTRIES(ENTRIES), .HIST_W(HIST_W), .PC_W(PC_W)) u_dut (
        .clk (clk), .rst (rst),
        .lk_valid (lk_valid), .lk_pc (lk_pc),
        .rs_valid (rs_valid), .rs_pc (rs_pc), .rs_taken (rs_taken),
        .rs_mispredict (rs_mispredict), .rs_target (rs_target),
        .flush (flush),
        .pred_hit (pred_hit), .pred_taken (pred_taken), .pred_target (pred_target)
    );

    typedef struct packed {
        logic        lk_v;
        logic [15:0] lk_pc;
        logic        rs_v;
        logic [15:0] rs_pc;
        logic        rs_t;
        logic        rs_m;
        logic [15:0] rs_tgt;
        logic        fl;
        logic        e_hit;
        logic        e_tk;
        logic [15:0] e_tgt;
        logic [3:0]  req;
    } vec_t;

    localparam logic [15:0] PA = 16'h0010, TA = 16'h0110;
    localparam logic [15:0] PB = 16'h0020, TB = 16'h0120;
    localparam logic [15:0] PC = 16'h0030, TC = 16'h0130;
    localparam logic [15:0] PD = 16'h0040, TD = 16'h0140;
    localparam logic [15:0] PE = 16'h0050, TE = 16'h0150;
    localparam logic [15:0] Z  = 16'h0000;

    localparam int NV = 33;
    // lk_v lk_pc rs_v rs_pc t m tgt fl | hit tk tgt req
    localparam vec_t TBL [NV] = '{
        '{1, PA, 0, Z,  0, 0, Z,  0, 0, 0, Z,  1},  // 0  R1 empty table misses
        '{0, PA, 1, PA, 1, 1, TA, 0, 0, 0, Z, 11},  // 1  R11 idle lookup, A allocated
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 2},  // 2  R2 hit, hist 0001
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 3  R6 spec 0010
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 4  spec 0100
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 5  spec 1000 -> 0000
        '{0, PA, 0, Z,  0, 0, Z,  0, 0, 0, Z, 11},  // 6  R11 spec must stay 0000
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 1, TA, 5},  // 7  R5 spec 0000 picks trained ctr
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 8  spec 0001
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 9  spec 0010
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 10 spec 0100
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 11 spec 1000 -> 0000
        '{1, PA, 0, Z,  0, 0, Z,  1, 1, 0, TA, 8},  // 12 R8 flush: committed 0001
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 13 spec 0010
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 14 spec 0100
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 15 spec 1000 -> 0000
        '{0, Z,  1, PA, 1, 1, TA, 0, 0, 0, Z,  7},  // 16 R7 trains ctr[0001], bhr 0011
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 8},  // 17 R8 mispredict dropped spec 0000
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 18 spec 0110
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 19 spec 1100
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 6},  // 20 spec 1000
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 1, TA, 4},  // 21 R4 ctr[0000] untouched by lookups
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 1, TA, 7},  // 22 R7 ctr[0001] was the trained one
        '{1, PB, 1, PB, 1, 1, TB, 0, 1, 0, TB,10},  // 23 R10 same-cycle allocate and lookup
        '{0, Z,  1, PC, 0, 0, TC, 0, 0, 0, Z,  9},  // 24 C allocated
        '{0, Z,  1, PD, 0, 0, TD, 0, 0, 0, Z,  9},  // 25 D allocated, table full
        '{1, PA, 0, Z,  0, 0, Z,  0, 1, 0, TA, 3},  // 26 A committed 0011 weak NT
        '{0, Z,  1, PE, 1, 1, TE, 0, 0, 0, Z,  9},  // 27 E wraps onto entry 0
        '{1, PA, 0, Z,  0, 0, Z,  0, 0, 0, Z,  9},  // 28 R9 A evicted
        '{1, PB, 0, Z,  0, 0, Z,  0, 1, 0, TB, 9},  // 29 B kept
        '{1, PE, 0, Z,  0, 0, Z,  0, 1, 0, TE, 2},  // 30 E present
        '{1, PC, 0, Z,  0, 0, Z,  0, 1, 0, TC, 3},  // 31 C ctr[0000]=0
        '{1, PC, 1, PC, 0, 0, TC, 0, 1, 0, TC, 3}   // 32 R3 saturates at 0, no wrap to 3
    };

    task automatic check(input string what, input int req, input logic h, input logic t,
                         input logic [PC_W-1:0] g, input logic eh, input logic et,
                         input logic [PC_W-1:0] eg);
        total++;
        if (h !== eh || t !== et || g !== eg) begin
            bad++;
            $display("FAIL R%0d %s: got hit=%0b taken=%0b target=%h, expected hit=%0b taken=%0b target=%h",
                     req, what, h, t, g, eh, et, eg);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; lk_pc = '0; rs_valid = 1'b0; rs_pc = '0;
        rs_taken = 1'b0; rs_mispredict = 1'b0; rs_target = '0; flush = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lk_valid      = TBL[i].lk_v;
            lk_pc         = TBL[i].lk_pc;
            rs_valid      = TBL[i].rs_v;
            rs_pc         = TBL[i].rs_pc;
            rs_taken      = TBL[i].rs_t;
            rs_mispredict = TBL[i].rs_m;
            rs_target     = TBL[i].rs_tgt;
            flush         = TBL[i].fl;
            #1;
            check($sformatf("row %0d", i), int'(TBL[i].req), pred_hit, pred_taken, pred_target,
                  TBL[i].e_hit, TBL[i].e_tk, TBL[i].e_tgt);
        end
        // R2: D still resident with committed history 0000, counter weakly not-taken lowered to 0
        @(negedge clk);
        idle_inputs();
        lk_valid = 1'b1; lk_pc = PD;
        #1;
        check("D lookup", 2, pred_hit, pred_taken, pred_target, 1'b1, 1'b0, TD);
        // R1: reset empties the table
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        lk_valid = 1'b1; lk_pc = PB;
        #1;
        check("lookup after reset", 1, pred_hit, pred_taken, pred_target, 1'b0, 1'b0, '0);
        @(negedge clk);
        idle_inputs();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL R1 watchdog: got running, expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule